// File: doc/BRIEF.md
# Quad DAC Parallel Write Sequencer

This block sits between a host and the parallel load port of a four-channel, 8-bit voltage-output converter. The host offers a write with a valid/ready handshake that carries a 2-bit channel index and an 8-bit code. The block drives the converter's shared data bus, its two channel-select lines and its active-low write strobe. Each write runs as a fixed sequence: select and data go onto the bus, the strobe falls, the strobe rises, and the bus is held before the next request can be taken.

The converter's channel latches follow their input for as long as the strobe is low, so any change on the bus inside that window shows up at the analog output. For that reason the bus changes only while the strobe is high and the sequencer is idle. The setup, strobe and hold intervals are given in picoseconds. Each one becomes a whole number of clock cycles, found by ceiling division by the clock-period parameter, with at least one cycle per interval.

The block also keeps a shadow copy of the last code written to each channel. The host reads it through a select input, and the registered result appears one cycle later.

Top module: `quad_dac_writer`

## Requirements
- R1: After a synchronous reset the strobe `dac_wr_n` is 1, `req_ready` is 1, `dac_data` and `dac_sel` are 0, and every shadow entry reads 0.
- R2: An accepted channel index n drives `dac_sel` = n, where bit 1 is the more significant select line: index 0 gives 00, 1 gives 01, 2 gives 10 and 3 gives 11. `dac_data` carries the accepted code.
- R3: After a request is accepted, the strobe stays high for SETUP_CYC cycles with the new select and data on the bus. SETUP_CYC is the address setup time divided by the clock period, rounded up, and at least 1.
- R4: The strobe is low for exactly PULSE_CYC consecutive cycles. PULSE_CYC is the larger of the minimum pulse width and the data setup time, divided by the clock period, rounded up, and at least 1.
- R5: After the strobe rises, the block stays busy (`req_ready` low) for HOLD_CYC cycles with the bus unchanged. HOLD_CYC is the larger of the address and data hold times, divided by the clock period, rounded up, and at least 1.
- R6: `dac_data` and `dac_sel` change only on the clock edge that accepts a request. In particular they never change while the strobe is low.
- R7: `req_ready` is high only when the sequencer is idle. A request held valid while the block is busy is not taken until the current write has finished, and it does not disturb that write.
- R8: A channel's shadow entry takes the written code on the edge that ends the hold interval. `rd_code` shows the entry chosen by `rd_chan` one cycle after it is selected. Entries of other channels are unchanged.
- R9: When no request is valid, the strobe stays high and the bus does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host write request valid |
| req_ready | output | 1 | Sequencer idle, request accepted when valid |
| req_chan | input | SEL_W | Target channel index |
| req_code | input | DATA_W | Code to write |
| rd_chan | input | SEL_W | Shadow read select |
| rd_code | output | DATA_W | Shadow value, one cycle after select |
| dac_data | output | DATA_W | Shared converter data bus |
| dac_sel | output | SEL_W | Converter channel-select lines |
| dac_wr_n | output | 1 | Active-low write strobe |

## Verification
The assertions assume that reset is held for at least one clock edge and that the host uses the usual handshake: a request counts as accepted only on an edge where `req_valid` and `req_ready` are both high. Nothing is assumed about when the host raises `req_valid`. The checks rely only on the bus changing at an accepting edge. The stimulus drives every input at the falling clock edge. It also leaves requests valid across busy periods, which exercises a host that keeps asking while a write is in progress.

// File: rtl/qdw_pkg.sv
package qdw_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETUP  = 2'd1,
    ST_STROBE = 2'd2,
    ST_HOLD   = 2'd3
  } qdw_state_e;

  // whole cycles covering a time, never fewer than one
  function automatic int cycles_for(input int time_ps, input int period_ps);
    int r;
    r = (time_ps + period_ps - 1) / period_ps;
    return (r < 1) ? 1 : r;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/qdw_interval.sv
module qdw_interval #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)
      cnt_q <= '0;
    else if (load)
      cnt_q <= load_val;
    else if (cnt_q != '0)
      cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/qdw_seq.sv
module qdw_seq
  import qdw_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int SEL_W     = 2,
  parameter int SETUP_CYC = 1,
  parameter int PULSE_CYC = 13,
  parameter int HOLD_CYC  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [SEL_W-1:0]  req_chan,
  input  logic [DATA_W-1:0] req_code,
  output logic [DATA_W-1:0] dac_data,
  output logic [SEL_W-1:0]  dac_sel,
  output logic              dac_wr_n,
  output logic              done
);
  localparam int MAX_CYC = max2(max2(SETUP_CYC, PULSE_CYC), HOLD_CYC);
  localparam int CNT_W   = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);
  localparam logic [CNT_W-1:0] SETUP_LD = CNT_W'(SETUP_CYC - 1);
  localparam logic [CNT_W-1:0] PULSE_LD = CNT_W'(PULSE_CYC - 1);
  localparam logic [CNT_W-1:0] HOLD_LD  = CNT_W'(HOLD_CYC - 1);

  qdw_state_e       state_q;
  logic             accept;
  logic             ld;
  logic [CNT_W-1:0] ld_val;
  logic             expired;

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign done      = (state_q == ST_HOLD) && expired;

  qdw_interval #(.CNT_W(CNT_W)) u_interval (
    .clk      (clk),
    .rst      (rst),
    .load     (ld),
    .load_val (ld_val),
    .expired  (expired)
  );

  always_comb begin
    ld     = 1'b0;
    ld_val = SETUP_LD;
    unique case (state_q)
      ST_IDLE:   begin ld = accept;  ld_val = SETUP_LD; end
      ST_SETUP:  begin ld = expired; ld_val = PULSE_LD; end
      ST_STROBE: begin ld = expired; ld_val = HOLD_LD;  end
      default:   begin ld = 1'b0;    ld_val = SETUP_LD; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      dac_data <= '0;
      dac_sel  <= '0;
      dac_wr_n <= 1'b1;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept) begin
          dac_data <= req_code;
          dac_sel  <= req_chan;
          state_q  <= ST_SETUP;
        end
        ST_SETUP: if (expired) begin
          dac_wr_n <= 1'b0;
          state_q  <= ST_STROBE;
        end
        ST_STROBE: if (expired) begin
          dac_wr_n <= 1'b1;
          state_q  <= ST_HOLD;
        end
        default: if (expired) state_q <= ST_IDLE;
      endcase
    end
  end

  // checker state: edges since reset and length of the current low run
  logic             armed_q;
  logic [CNT_W:0]   low_run_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q   <= 1'b0;
      low_run_q <= '0;
    end else begin
      armed_q   <= 1'b1;
      low_run_q <= dac_wr_n ? '0 : low_run_q + 1'b1;
    end
  end

  AST_BUS_FROZEN_LOW: assert property (@(posedge clk) disable iff (rst || !armed_q)
    (!dac_wr_n && !$past(dac_wr_n)) |-> ($stable(dac_data) && $stable(dac_sel))); // R6
  AST_BUS_ONLY_ON_ACCEPT: assert property (@(posedge clk) disable iff (rst || !armed_q)
    (!$stable(dac_data) || !$stable(dac_sel)) |-> $past(req_valid && req_ready)); // R6
  AST_NOT_READY_IN_STROBE: assert property (@(posedge clk) disable iff (rst)
    !dac_wr_n |-> !req_ready); // R7
  AST_PULSE_BOUND: assert property (@(posedge clk) disable iff (rst)
    !dac_wr_n |-> (low_run_q < (CNT_W+1)'(PULSE_CYC))); // R4
  AST_PULSE_EXACT: assert property (@(posedge clk) disable iff (rst || !armed_q)
    $rose(dac_wr_n) |-> ($past(low_run_q) == (CNT_W+1)'(PULSE_CYC - 1))); // R4
  AST_FALL_NOT_FROM_IDLE: assert property (@(posedge clk) disable iff (rst || !armed_q)
    $fell(dac_wr_n) |-> !$past(req_ready)); // R3
endmodule

// File: rtl/qdw_shadow.sv
module qdw_shadow #(
  parameter int NUM_CH = 4,
  parameter int DATA_W = 8,
  parameter int SEL_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [SEL_W-1:0]  wsel,
  input  logic [DATA_W-1:0] wdata,
  input  logic [SEL_W-1:0]  rsel,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem_q [NUM_CH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_CH; i++) mem_q[i] <= '0;
      rdata <= '0;
    end else begin
      if (we) mem_q[wsel] <= wdata;
      rdata <= mem_q[rsel];
    end
  end
endmodule

// File: rtl/quad_dac_writer.sv
module quad_dac_writer
  import qdw_pkg::*;
#(
  parameter int NUM_CH        = 4,
  parameter int DATA_W        = 8,
  parameter int SEL_W         = $clog2(NUM_CH),
  parameter int CLK_PERIOD_PS = 4000,
  parameter int ADDR_SU_PS    = 0,
  parameter int DATA_SU_PS    = 45000,
  parameter int PULSE_PS      = 50000,
  parameter int ADDR_HD_PS    = 0,
  parameter int DATA_HD_PS    = 10000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [SEL_W-1:0]  req_chan,
  input  logic [DATA_W-1:0] req_code,
  input  logic [SEL_W-1:0]  rd_chan,
  output logic [DATA_W-1:0] rd_code,
  output logic [DATA_W-1:0] dac_data,
  output logic [SEL_W-1:0]  dac_sel,
  output logic              dac_wr_n
);
  localparam int SETUP_CYC = cycles_for(ADDR_SU_PS, CLK_PERIOD_PS);
  localparam int PULSE_CYC = cycles_for(max2(PULSE_PS, DATA_SU_PS), CLK_PERIOD_PS);
  localparam int HOLD_CYC  = cycles_for(max2(ADDR_HD_PS, DATA_HD_PS), CLK_PERIOD_PS);

  logic write_done;

  qdw_seq #(
    .DATA_W(DATA_W), .SEL_W(SEL_W),
    .SETUP_CYC(SETUP_CYC), .PULSE_CYC(PULSE_CYC), .HOLD_CYC(HOLD_CYC)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_chan  (req_chan),
    .req_code  (req_code),
    .dac_data  (dac_data),
    .dac_sel   (dac_sel),
    .dac_wr_n  (dac_wr_n),
    .done      (write_done)
  );

  qdw_shadow #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .SEL_W(SEL_W)) u_shadow (
    .clk   (clk),
    .rst   (rst),
    .we    (write_done),
    .wsel  (dac_sel),
    .wdata (dac_data),
    .rsel  (rd_chan),
    .rdata (rd_code)
  );

  AST_SHADOW_AFTER_HOLD: assert property (@(posedge clk) disable iff (rst)
    write_done |-> (dac_wr_n && !req_ready)); // R8
  AST_READY_DONE_NEXT: assert property (@(posedge clk) disable iff (rst)
    write_done |=> req_ready); // R5
endmodule

// File: tb/sim_quad_dac_writer.sv
module sim_quad_dac_writer;
  localparam int PER_PS = 4000;
  // expected cycle counts worked out from the timing figures
  localparam int EXP_SU = 1;   // 0 ps setup -> minimum 1
  localparam int EXP_LO = 13;  // 50000 ps / 4000 ps = 12.5 -> 13
  localparam int EXP_HO = 3;   // 10000 ps / 4000 ps = 2.5 -> 3

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [1:0] req_chan = '0;
  logic [7:0] req_code = '0;
  logic [1:0] rd_chan = '0;
  logic [7:0] rd_code;
  logic [7:0] dac_data;
  logic [1:0] dac_sel;
  logic dac_wr_n;

  int checks = 0;
  int failures = 0;
  logic [7:0] model [4];

  always #2ns clk = ~clk;

  quad_dac_writer #(.CLK_PERIOD_PS(PER_PS)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_chan(req_chan), .req_code(req_code), .rd_chan(rd_chan), .rd_code(rd_code),
    .dac_data(dac_data), .dac_sel(dac_sel), .dac_wr_n(dac_wr_n)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic read_chk(input logic [1:0] ch, input logic [7:0] exp, input string req);
    @(negedge clk); rd_chan = ch;
    @(negedge clk); check(req, rd_code, exp);
  endtask

  // one full write; valid is dropped after the accepting edge
  task automatic do_write(input logic [1:0] ch, input logic [7:0] code);
    int hi, lo, ho, bad;
    hi = 0; lo = 0; ho = 0; bad = 0;
    @(negedge clk);
    check("R7 ready before write", req_ready, 1);
    req_valid = 1'b1; req_chan = ch; req_code = code;
    @(negedge clk);
    req_valid = 1'b0;
    check("R2 sel", dac_sel, ch);
    check("R2 data", dac_data, code);
    while (dac_wr_n && hi < 100) begin
      if (dac_data != code || dac_sel != ch) bad++;
      hi++; @(negedge clk);
    end
    while (!dac_wr_n && lo < 100) begin
      if (dac_data != code || dac_sel != ch || req_ready) bad++;
      lo++; @(negedge clk);
    end
    while (!req_ready && ho < 100) begin
      if (dac_data != code || dac_sel != ch || !dac_wr_n) bad++;
      ho++; @(negedge clk);
    end
    check("R3 setup cycles", hi, EXP_SU);
    check("R4 strobe low cycles", lo, EXP_LO);
    check("R5 hold cycles", ho, EXP_HO);
    check("R6 bus stable through write", bad, 0);
    model[ch] = code;
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R1 wr_n", dac_wr_n, 1);
    check("R1 ready", req_ready, 1);
    check("R1 data", dac_data, 0);
    check("R1 sel", dac_sel, 0);
    for (int c = 0; c < 4; c++) read_chk(2'(c), 8'h00, "R1 shadow");
  endtask

  task automatic t_all_channels;
    do_write(2'd0, 8'hA5);
    do_write(2'd1, 8'h3C);
    do_write(2'd2, 8'hFF);
    do_write(2'd3, 8'h00);
    do_write(2'd2, 8'h81);
    for (int c = 0; c < 4; c++) read_chk(2'(c), model[c], "R8 shadow readback");
  endtask

  task automatic t_idle_quiet;
    int bad;
    bad = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      req_code = 8'(i * 7); req_chan = 2'(i);
      if (!dac_wr_n || dac_data != model[2] || dac_sel != 2'd2) bad++;
    end
    check("R9 no request no strobe", bad, 0);
  endtask

  task automatic t_busy_request;
    int bad, lo;
    bad = 0; lo = 0;
    @(negedge clk);
    req_valid = 1'b1; req_chan = 2'd1; req_code = 8'h5A;
    @(negedge clk);
    req_chan = 2'd3; req_code = 8'hC3;   // second request, kept valid while busy
    while (!req_ready) begin
      if (dac_data != 8'h5A || dac_sel != 2'd1) bad++;
      if (!dac_wr_n) lo++;
      @(negedge clk);
    end
    check("R7 busy request does not disturb", bad, 0);
    check("R4 strobe width first write", lo, EXP_LO);
    @(negedge clk);                      // accepted at the edge in between
    req_valid = 1'b0;
    check("R7 queued request taken when idle sel", dac_sel, 3);
    check("R7 queued request taken when idle data", dac_data, 8'hC3);
    while (!req_ready) @(negedge clk);
    model[1] = 8'h5A; model[3] = 8'hC3;
    read_chk(2'd1, 8'h5A, "R8 shadow ch1");
    read_chk(2'd3, 8'hC3, "R8 shadow ch3");
    read_chk(2'd0, model[0], "R8 other channel unchanged");
  endtask

  task automatic t_shadow_timing;
    // read select fixed on the target channel; value moves only after hold ends
    @(negedge clk); rd_chan = 2'd0;
    req_valid = 1'b1; req_chan = 2'd0; req_code = 8'h77;
    @(negedge clk); req_valid = 1'b0;
    while (!req_ready) begin
      check("R8 shadow unchanged during write", rd_code, model[0]);
      @(negedge clk);
    end
    // write landed on the edge leaving hold; registered read shows it one edge later
    @(negedge clk);
    check("R8 shadow after hold", rd_code, 8'h77);
    model[0] = 8'h77;
  endtask

  initial begin
    for (int c = 0; c < 4; c++) model[c] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_all_channels();
    t_idle_quiet();
    t_busy_request();
    t_shadow_timing();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule